// File: doc/BRIEF.md
# Broadcast Storm Rate Limiter

This block guards one switch ingress port against broadcast storms. It meters the broadcast traffic the port accepts in units of 64-byte blocks. When the blocks used in the current measurement window reach a programmed budget, it refuses further broadcast frames until the window rolls over. Frames that are not broadcast are never metered and never refused.

The receive path presents each frame as a start strobe, an end strobe and a per-byte valid strobe. A broadcast flag is valid with the start strobe. The block returns one verdict per frame, one cycle after the start strobe, and the receive path discards the frame when the verdict says so. The window length is counted in pulses of a 1 ms enable. A window lasts 67 pulses on a 100 Mb/s link and 500 pulses on a 10 Mb/s link. The budget is an 11-bit block count, supplied as a 3-bit upper part and an 8-bit lower part. A budget near one percent of line rate is about 131 blocks at 100 Mb/s.

Top module: `bcast_storm_limiter`

## Requirements
- R1: After reset, `verdict_vld` and `verdict_drop` are 0 and the block count is zero, so the first broadcast frame under any non-zero budget is accepted.
- R2: A frame whose `rx_bcast` is 0 at its start is always accepted and adds nothing to the block count.
- R3: The budget is `{thr_upper, thr_lower}` (upper part in bits 10:8). A broadcast frame is dropped exactly when the window's block count is at least the budget at its start cycle; otherwise it is accepted.
- R4: An accepted broadcast frame adds its length rounded up to whole 64-byte blocks to the count. Its length is the number of cycles with `rx_bvalid` high, from the start cycle through the end cycle inclusive.
- R5: A dropped broadcast frame adds nothing to the block count.
- R6: The count returns to zero when the window ends. The window ends on the 67th `tick_ms` pulse after its start when `link_fast` is 1, and on the 500th when it is 0. A frame starting in the same cycle as the pulse that ends the window is judged against a count of zero.
- R7: Any change of `link_fast` clears the block count and starts a fresh window.
- R8: A budget of zero disables limiting: every frame is accepted.
- R9: `verdict_vld` is high for exactly one cycle, the cycle after each `rx_sof`, and is low otherwise. `verdict_drop` is only high together with `verdict_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| link_fast | input | 1 | Link rate: 1 = 100 Mb/s, 0 = 10 Mb/s |
| thr_upper | input | 3 | Upper bits of the block budget |
| thr_lower | input | 8 | Lower bits of the block budget |
| rx_sof | input | 1 | First cycle of a frame |
| rx_eof | input | 1 | Last cycle of a frame |
| rx_bvalid | input | 1 | One frame byte present this cycle |
| rx_bcast | input | 1 | Frame is broadcast; valid with rx_sof |
| verdict_vld | output | 1 | Verdict for the frame started in the previous cycle |
| verdict_drop | output | 1 | 1 = discard that frame |

## Verification
The properties assume a well-formed receive stream. A new start strobe only comes on or after the cycle that carries the previous frame's end strobe. The broadcast flag is only meaningful in the start cycle. The millisecond tick is a single-cycle pulse. The bench drives whole frames back to back with an idle cycle between them, and it keeps the tick low except for single-cycle pulses. It changes the link rate and the budget only between frames, apart from one deliberate case where a tick ending the window coincides with a frame start.

// File: rtl/storm_pkg.sv
// Shared types for the broadcast storm limiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package storm_pkg;

    // Link rate as seen by the window timer
    typedef enum logic {
        LINK_SLOW = 1'b0,
        LINK_FAST = 1'b1
    } link_rate_e;

    // Per-frame verdict returned to the receive path
    typedef struct packed {
        logic vld;
        logic drop;
    } verdict_t;

endpackage

// File: rtl/storm_window.sv
// Measurement window timer.
// Counts 1 ms pulses and flags the end of each window. The window is
// FAST_MS pulses long on a fast link and SLOW_MS on a slow one. A change
// of link rate restarts the window and is flagged in the same way.
// Assumes tick is a single-cycle pulse.
module storm_window
    import storm_pkg::*;
#(
    parameter int FAST_MS = 67,
    parameter int SLOW_MS = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  link_rate_e rate,
    output logic       win_clr
);
    localparam int WIN_MAX = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS;
    localparam int WIN_W   = $clog2(WIN_MAX);

    logic [WIN_W-1:0] tick_cnt;
    logic [WIN_W-1:0] last_idx;
    link_rate_e       rate_q;
    logic             rate_chg;
    logic             win_end;

    // Pick the last pulse index of the window for the current rate
    always_comb begin
        last_idx = (rate == LINK_FAST) ? WIN_W'(FAST_MS - 1) : WIN_W'(SLOW_MS - 1);
        rate_chg = (rate != rate_q);
        win_end  = tick && !rate_chg && (tick_cnt == last_idx);
        win_clr  = win_end || rate_chg;
    end

    // Advance the pulse counter and remember the rate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            rate_q   <= LINK_SLOW;
        end else begin
            rate_q <= rate;
            if (rate_chg || win_end) begin
                tick_cnt <= '0;
            end else if (tick) begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/storm_meter.sv
// Block usage meter.
// While an accepted frame is in flight, counts one block on the first
// byte of every BLK_BYTES-byte chunk, giving the length rounded up.
// The count clears on win_clr and saturates at its maximum.
// Assumes BLK_BYTES is a power of two and frames do not overlap.
module storm_meter #(
    parameter int BLK_BYTES = 64,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             eof,
    input  logic             bvalid,
    input  logic             accept,
    input  logic             win_clr,
    output logic [CNT_W-1:0] count
);
    localparam int POS_W = $clog2(BLK_BYTES);

    logic             active;
    logic [POS_W-1:0] pos;
    logic             act_now;
    logic [POS_W-1:0] pos_now;
    logic             bump;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_nxt;

    // Work out whether this cycle opens a new block
    always_comb begin
        act_now = sof ? accept : active;
        pos_now = sof ? '0 : pos;
        bump    = act_now && bvalid && (pos_now == '0);
        base    = win_clr ? '0 : count;
        if (bump && (base != {CNT_W{1'b1}})) begin
            cnt_nxt = base + 1'b1;
        end else begin
            cnt_nxt = base;
        end
    end

    // Track frame state, byte position and block count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
            count  <= '0;
        end else begin
            active <= act_now && !eof;
            if (act_now && bvalid) begin
                pos <= pos_now + 1'b1;
            end else begin
                pos <= pos_now;
            end
            count <= cnt_nxt;
        end
    end

endmodule

// File: rtl/storm_gate.sv
// Admission decision.
// At a frame start, refuses a broadcast frame when the window count has
// reached a non-zero budget. A window ending in the same cycle counts as
// zero usage. Registers the verdict for the following cycle.
// Assumes bcast is meaningful only when sof is high.
module storm_gate
    import storm_pkg::*;
#(
    parameter int THR_W = 11,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             bcast,
    input  logic [THR_W-1:0] thr,
    input  logic [CNT_W-1:0] count,
    input  logic             win_clr,
    output logic             accept,
    output verdict_t         verdict
);
    logic [CNT_W-1:0] used;
    logic [CNT_W-1:0] budget;
    logic             refuse;

    // Compare current usage against the budget
    always_comb begin
        used   = win_clr ? '0 : count;
        budget = CNT_W'(thr);
        refuse = sof && bcast && (thr != '0) && (used >= budget);
        accept = sof && bcast && !refuse;
    end

    // Hold the verdict for one cycle after the frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict <= '0;
        end else begin
            verdict.vld  <= sof;
            verdict.drop <= refuse;
        end
    end

endmodule

// File: rtl/bcast_storm_limiter.sv
// Broadcast storm limiter for one ingress port.
// Joins the window timer, the block meter and the admission gate.
// Budget is {thr_upper, thr_lower} in blocks; zero disables limiting.
// Assumes a well-formed frame stream and a single-cycle 1 ms tick.
module bcast_storm_limiter
    import storm_pkg::*;
#(
    parameter int WIN_FAST_MS = 67,
    parameter int WIN_SLOW_MS = 500,
    parameter int BLK_BYTES   = 64,
    parameter int THR_HI_W    = 3,
    parameter int THR_LO_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_ms,
    input  logic                link_fast,
    input  logic [THR_HI_W-1:0] thr_upper,
    input  logic [THR_LO_W-1:0] thr_lower,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic                rx_bvalid,
    input  logic                rx_bcast,
    output logic                verdict_vld,
    output logic                verdict_drop
);
    localparam int THR_W = THR_HI_W + THR_LO_W;
    localparam int CNT_W = THR_W + 1;

    logic [THR_W-1:0] thr;
    logic [CNT_W-1:0] blk_count;
    logic             win_clr;
    logic             accept;
    link_rate_e       rate;
    verdict_t         verdict;

    // Assemble the budget and decode the link rate
    always_comb begin
        thr  = {thr_upper, thr_lower};
        rate = link_fast ? LINK_FAST : LINK_SLOW;
    end

    storm_window #(
        .FAST_MS (WIN_FAST_MS),
        .SLOW_MS (WIN_SLOW_MS)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .rate    (rate),
        .win_clr (win_clr)
    );

    storm_meter #(
        .BLK_BYTES (BLK_BYTES),
        .CNT_W     (CNT_W)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (rx_sof),
        .eof     (rx_eof),
        .bvalid  (rx_bvalid),
        .accept  (accept),
        .win_clr (win_clr),
        .count   (blk_count)
    );

    storm_gate #(
        .THR_W (THR_W),
        .CNT_W (CNT_W)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (rx_sof),
        .bcast   (rx_bcast),
        .thr     (thr),
        .count   (blk_count),
        .win_clr (win_clr),
        .accept  (accept),
        .verdict (verdict)
    );

    // Drive the verdict ports
    always_comb begin
        verdict_vld  = verdict.vld;
        verdict_drop = verdict.drop;
    end

endmodule

// File: rtl/storm_checker.sv
// Property checker for bcast_storm_limiter, attached by bind.
// Assumes the frame stream and tick rules stated in the brief.
module storm_checker #(
    parameter int THR_W = 11,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_sof,
    input logic             rx_bcast,
    input logic [THR_W-1:0] thr,
    input logic [CNT_W-1:0] blk_count,
    input logic             win_clr,
    input logic             verdict_vld,
    input logic             verdict_drop
);
    // R9: a verdict follows every frame start
    p_vld_after_sof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> verdict_vld);

    // R9: no verdict without a frame start
    p_no_stray_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_sof |=> !verdict_vld);

    // R9: drop only accompanies a valid verdict
    p_drop_with_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_drop |-> verdict_vld);

    // R2: non-broadcast frames pass
    p_plain_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && !rx_bcast) |=> !verdict_drop);

    // R8: zero budget never drops
    p_zero_budget_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && (thr == '0)) |=> !verdict_drop);

    // R3: usage below budget is admitted
    p_below_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && !win_clr && (blk_count < CNT_W'(thr))) |=> !verdict_drop);

    // R6: a window clear leaves at most the block opened in that cycle
    p_window_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_clr |=> (blk_count <= CNT_W'(1)));

    // R4: within a window the count grows by at most one block per cycle
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_clr |=> ((blk_count == $past(blk_count)) ||
                      (blk_count == $past(blk_count) + 1'b1)));

endmodule

bind bcast_storm_limiter storm_checker #(
    .THR_W (THR_W),
    .CNT_W (CNT_W)
) u_storm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_sof       (rx_sof),
    .rx_bcast     (rx_bcast),
    .thr          (thr),
    .blk_count    (blk_count),
    .win_clr      (win_clr),
    .verdict_vld  (verdict_vld),
    .verdict_drop (verdict_drop)
);

// File: tb/sim_bcast_storm_limiter.sv
module sim_bcast_storm_limiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       link_fast = 1'b1;
    logic [2:0] thr_upper = '0;
    logic [7:0] thr_lower = '0;
    logic       rx_sof = 1'b0;
    logic       rx_eof = 1'b0;
    logic       rx_bvalid = 1'b0;
    logic       rx_bcast = 1'b0;
    logic       verdict_vld;
    logic       verdict_drop;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bcast_storm_limiter u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_ms      (tick_ms),
        .link_fast    (link_fast),
        .thr_upper    (thr_upper),
        .thr_lower    (thr_lower),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_bvalid    (rx_bvalid),
        .rx_bcast     (rx_bcast),
        .verdict_vld  (verdict_vld),
        .verdict_drop (verdict_drop)
    );

    // Columns: broadcast, length in bytes, budget, expected drop, tag code
    localparam int NV = 14;
    localparam int VEC [NV][5] = '{
        '{1, 100, 3, 0, 4},   // R4: 100 B -> 2 blocks, count 2
        '{0, 500, 3, 0, 2},   // R2: plain frame, count stays 2
        '{1,  64, 3, 0, 4},   // R4: 64 B -> 1 block, count 3
        '{1,  10, 3, 1, 3},   // R3: 3 >= 3 -> drop
        '{0,  10, 3, 0, 2},   // R2: plain frame at full budget passes
        '{1,   1, 4, 0, 5},   // R5: dropped frame added nothing, count 3 < 4
        '{1,  65, 4, 1, 3},   // R3: 4 >= 4 -> drop
        '{1, 300, 0, 0, 8},   // R8: zero budget, accepted, +5 -> 9
        '{1,   1, 9, 1, 3},   // R3: 9 >= 9 -> drop
        '{1,   1,10, 0, 3},   // R3: 9 < 10, +1 -> 10
        '{1, 128,11, 0, 4},   // R4: 128 B -> exactly 2 blocks, 12
        '{1,   1,12, 1, 4},   // R4: 12 >= 12 -> drop
        '{1,   1,13, 0, 4},   // R4: 12 < 13, +1 -> 13
        '{1,   1,13, 1, 3}    // R3: 13 >= 13 -> drop
    };

    function automatic string tag(input int code);
        case (code)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_thr(input int t);
        @(negedge clk);
        thr_upper = 3'(t >> 8);
        thr_lower = 8'(t);
    endtask

    // Send one frame; check its verdict and the idle cycle after it
    task automatic send(input bit bc, input int nb, input bit exp_drop,
                        input bit with_tick, input string req);
        @(negedge clk);
        rx_sof = 1'b1; rx_bcast = bc; rx_bvalid = 1'b1;
        rx_eof = (nb == 1); tick_ms = with_tick;
        @(posedge clk); #1;
        chk(req, int'({verdict_vld, verdict_drop}), int'({1'b1, exp_drop}));
        for (int i = 1; i < nb; i++) begin
            @(negedge clk);
            rx_sof = 1'b0; tick_ms = 1'b0; rx_eof = (i == nb - 1);
        end
        @(negedge clk);
        rx_sof = 1'b0; rx_eof = 1'b0; rx_bvalid = 1'b0; rx_bcast = 1'b0;
        tick_ms = 1'b0;
        @(posedge clk); #1;
        chk("R9 idle", int'({verdict_vld, verdict_drop}), 0);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
        end
    endtask

    // Two rate changes, ending on the fast rate with a fresh window
    task automatic restart_fast();
        @(negedge clk); link_fast = 1'b0;
        @(negedge clk); link_fast = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", int'({verdict_vld, verdict_drop}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset", int'({verdict_vld, verdict_drop}), 0);

        // Table walk on a fast link with no ticks
        for (int v = 0; v < NV; v++) begin
            set_thr(VEC[v][2]);
            send(VEC[v][0] != 0, VEC[v][1], VEC[v][3] != 0, 1'b0, tag(VEC[v][4]));
        end

        // R1: reset clears the count accumulated above
        set_thr(1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        send(1'b1, 1, 1'b0, 1'b0, "R1 first after reset");
        send(1'b1, 1, 1'b1, 1'b0, "R3 budget one");

        // R6: fast window ends on the 67th tick
        restart_fast();
        send(1'b1, 1, 1'b0, 1'b0, "R7 restart cleared");
        ticks(66);
        send(1'b1, 1, 1'b1, 1'b0, "R6 fast 66 ticks");
        ticks(1);
        send(1'b1, 1, 1'b0, 1'b0, "R6 fast window end");

        // R6: frame start coinciding with the ending tick sees zero
        restart_fast();
        send(1'b1, 1, 1'b0, 1'b0, "R7 restart cleared");
        ticks(66);
        send(1'b1, 1, 1'b0, 1'b1, "R6 same-cycle end");
        send(1'b1, 1, 1'b1, 1'b0, "R6 counted in new window");

        // R6: slow window ends on the 500th tick
        @(negedge clk); link_fast = 1'b0;
        send(1'b1, 1, 1'b0, 1'b0, "R7 slow switch cleared");
        ticks(499);
        send(1'b1, 1, 1'b1, 1'b0, "R6 slow 499 ticks");
        ticks(1);
        send(1'b1, 1, 1'b0, 1'b0, "R6 slow window end");

        // R7: rate change alone clears a full count
        @(negedge clk); link_fast = 1'b1;
        send(1'b1, 1, 1'b0, 1'b0, "R7 rate change");
        send(1'b1, 1, 1'b1, 1'b0, "R7 refill");

        // R3: budget upper part sits at bit 8 (budget 256)
        restart_fast();
        set_thr(256);
        send(1'b1, 16320, 1'b0, 1'b0, "R3 255 blocks");
        send(1'b1, 1, 1'b0, 1'b0, "R3 255 below 256");
        send(1'b1, 1, 1'b1, 1'b0, "R3 256 reached");
        send(1'b0, 1, 1'b0, 1'b0, "R2 plain at limit");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule